// File: doc/BRIEF.md
# Per-Line Black-Level Correction Loop

This block holds the black level of one 10-bit video channel at a programmed target. On each line a window pulse marks the pixels to measure. The block sums a power-of-two number of those pixels and shifts the sum down to get their mean. When the next line-sync pulse arrives, it compares the mean with the target. The difference goes through a first-order recursive filter that is set by a shift amount. The filtered value is a signed correction, and it is added to every pixel that follows.

The window can come from an internally generated pulse or from an external pin, chosen by a select input. The correction changes at most once per line. It is available on an output port as a 10-bit two's-complement value. A shift of zero makes the correction equal to the latest error, so the loop settles within one line. Larger shifts give a slower and smoother response. When the loop is disabled, the correction reads zero and pixels pass through without change.

Top module: `black_level_loop`

## Requirements
- R1: While `rst` is high on a clock edge, `corr_out` becomes 0 and `pix_out` becomes 0 after that edge.
- R2: The measured level of a line is the sum of the first 2^`nsh` pixels for which the selected window is high, shifted right by `nsh`. Later window pixels on that line are ignored. The window is `win_int` when `win_sel`=0 and `win_ext` when `win_sel`=1.
- R3: The correction changes only in the cycle after a `line_sync` cycle, and only if the window supplied at least 2^`nsh` pixels since the previous sync. Otherwise it holds.
- R4: The error is `target` minus the measured level, limited to the range -512..511. With `nsv`=0, the correction equals that error after the update.
- R5: With `nsv`>0, the correction becomes corr + ((error - corr) arithmetically shifted right by `nsv`), which rounds toward minus infinity.
- R6: While `loop_en` is low, the correction is 0 from the next cycle on, no update takes place, and `pix_out` repeats `pix_in` one cycle later.
- R7: `pix_out` is `pix_in` plus the value on `corr_out` in the same cycle, registered for one cycle, and saturated to 0..1023.
- R8: A pixel present in a `line_sync` cycle is not counted, even with the window high. The pixel count for the new line starts at zero.
- R9: `corr_out` is a 10-bit two's-complement number equal to the loop's internal correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 10 | Incoming pixel code |
| line_sync | input | 1 | One-cycle pulse marking a line boundary |
| win_int | input | 1 | Internally generated measurement window |
| win_ext | input | 1 | Measurement window from an external pin |
| win_sel | input | 1 | Window source select: 0 internal, 1 external |
| loop_en | input | 1 | Loop enable |
| nsv | input | 4 | Vertical filter shift (0 = one-line convergence) |
| nsh | input | 3 | Log2 of the number of pixels averaged |
| target | input | 10 | Target black level |
| pix_out | output | 10 | Corrected, saturated pixel |
| corr_out | output | 10 | Current signed correction |

## Verification
Two things can happen in the same cycle. A line-sync pulse can close the measurement while the window is still high, and the correction can update in the cycle in which a pixel is being corrected. The bench drives windows that overlap the sync cycle. Its reference model counts no pixel in that cycle, and it expects the pixel at the sync edge to use the old correction, with the new value applied from the next pixel on. Random lines with full-range pixels outside the window also push the corrected output against both saturation limits right after large correction steps.

// File: rtl/blc_pkg.sv
package blc_pkg;
    localparam int PIX_W = 10;
    localparam int PIX_MAX = (1 << PIX_W) - 1;
    localparam int ERR_HI = (1 << (PIX_W - 1)) - 1;
    localparam int ERR_LO = -(1 << (PIX_W - 1));

    // one measurement result handed from the averager to the filter
    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] level;
    } level_s;

    function automatic logic signed [PIX_W-1:0] clamp_err(input logic signed [PIX_W:0] e);
        if (e > (PIX_W+1)'(ERR_HI))
            return PIX_W'(ERR_HI);
        else if (e < (PIX_W+1)'(ERR_LO))
            return PIX_W'(ERR_LO);
        else
            return e[PIX_W-1:0];
    endfunction

    function automatic logic [PIX_W-1:0] sat_pix(input logic signed [PIX_W+1:0] s);
        if (s < 0)
            return '0;
        else if (s > (PIX_W+2)'(PIX_MAX))
            return PIX_W'(PIX_MAX);
        else
            return s[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/blc_avg.sv
module blc_avg
    import blc_pkg::*;
#(
    parameter int NSH_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync,
    input  logic             win,
    input  logic [PIX_W-1:0] pix,
    input  logic [NSH_W-1:0] nsh,
    output level_s           meas
);
    localparam int MAX_SH = (1 << NSH_W) - 1;
    localparam int MAX_CNT = 1 << MAX_SH;
    localparam int CNT_W = $clog2(MAX_CNT + 1);
    localparam int SUM_W = PIX_W + MAX_SH;

    logic [CNT_W-1:0] cnt;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] need;

    assign need = CNT_W'(1) << nsh;

    // a sync cycle closes the line and drops its own pixel (R8)
    always_ff @(posedge clk) begin
        if (rst || sync) begin
            cnt <= '0;
            sum <= '0;
        end else if (win && cnt < need) begin
            cnt <= cnt + CNT_W'(1);
            sum <= sum + SUM_W'(pix);
        end
    end

    always_comb begin
        meas.valid = sync && (cnt == need);
        meas.level = PIX_W'(sum >> nsh);
    end

    assert_fill_stop_R2: assert property (@(posedge clk) disable iff (rst)
        (win && !sync && cnt == need) |=> (cnt == $past(cnt)));

    assert_sync_restart_R8: assert property (@(posedge clk) disable iff (rst)
        sync |=> (cnt == '0));
endmodule

// File: rtl/blc_filter.sv
module blc_filter
    import blc_pkg::*;
#(
    parameter int NSV_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  level_s                  meas,
    input  logic [PIX_W-1:0]        target,
    input  logic [NSV_W-1:0]        nsv,
    output logic signed [PIX_W-1:0] acc
);
    logic signed [PIX_W:0]   err_w;
    logic signed [PIX_W-1:0] err;
    logic signed [PIX_W:0]   diff;
    logic signed [PIX_W:0]   step;

    always_comb begin
        err_w = $signed({1'b0, target}) - $signed({1'b0, meas.level});
        err   = clamp_err(err_w);
        diff  = $signed({err[PIX_W-1], err}) - $signed({acc[PIX_W-1], acc});
        step  = diff >>> nsv;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            acc <= '0;
        else if (meas.valid)
            acc <= PIX_W'($signed({acc[PIX_W-1], acc}) + step);
    end

    assert_acc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !meas.valid) |=> $stable(acc));

    assert_one_line_R4: assert property (@(posedge clk) disable iff (rst)
        (en && meas.valid && nsv == '0) |=> (acc == $past(err)));

    assert_off_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (acc == '0));
endmodule

// File: rtl/blc_apply.sv
module blc_apply
    import blc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PIX_W-1:0]        pix,
    input  logic signed [PIX_W-1:0] corr,
    output logic [PIX_W-1:0]        pix_out
);
    logic signed [PIX_W+1:0] total;

    assign total = $signed({2'b00, pix}) + $signed({{2{corr[PIX_W-1]}}, corr});

    always_ff @(posedge clk) begin
        if (rst)
            pix_out <= '0;
        else
            pix_out <= sat_pix(total);
    end

    assert_zero_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (corr == '0) |=> (pix_out == $past(pix)));
endmodule

// File: rtl/black_level_loop.sv
module black_level_loop
    import blc_pkg::*;
#(
    parameter int NSH_W = 3,
    parameter int NSV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             line_sync,
    input  logic             win_int,
    input  logic             win_ext,
    input  logic             win_sel,
    input  logic             loop_en,
    input  logic [NSV_W-1:0] nsv,
    input  logic [NSH_W-1:0] nsh,
    input  logic [PIX_W-1:0] target,
    output logic [PIX_W-1:0] pix_out,
    output logic [PIX_W-1:0] corr_out
);
    level_s                  meas;
    logic                    win;
    logic signed [PIX_W-1:0] acc;

    assign win = win_sel ? win_ext : win_int;

    blc_avg #(.NSH_W(NSH_W)) u_avg (
        .clk  (clk),
        .rst  (rst),
        .sync (line_sync),
        .win  (win),
        .pix  (pix_in),
        .nsh  (nsh),
        .meas (meas)
    );

    blc_filter #(.NSV_W(NSV_W)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .en     (loop_en),
        .meas   (meas),
        .target (target),
        .nsv    (nsv),
        .acc    (acc)
    );

    blc_apply u_apply (
        .clk     (clk),
        .rst     (rst),
        .pix     (pix_in),
        .corr    (acc),
        .pix_out (pix_out)
    );

    // R9: the correction is exposed unchanged as two's complement
    assign corr_out = acc;

    assert_update_sync_R3: assert property (@(posedge clk) disable iff (rst)
        (!line_sync && loop_en) |=> $stable(corr_out));
endmodule

// File: tb/black_level_loop_test.sv
module black_level_loop_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] pix_in = '0;
    logic       line_sync = 1'b0;
    logic       win_int = 1'b0;
    logic       win_ext = 1'b0;
    logic       win_sel = 1'b0;
    logic       loop_en = 1'b0;
    logic [3:0] nsv = '0;
    logic [2:0] nsh = '0;
    logic [9:0] target = '0;
    logic [9:0] pix_out;
    logic [9:0] corr_out;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    int m_sum = 0;
    int m_acc = 0;
    int seed;

    black_level_loop uut (
        .clk(clk), .rst(rst), .pix_in(pix_in), .line_sync(line_sync),
        .win_int(win_int), .win_ext(win_ext), .win_sel(win_sel),
        .loop_en(loop_en), .nsv(nsv), .nsh(nsh), .target(target),
        .pix_out(pix_out), .corr_out(corr_out)
    );

    always #4 clk = ~clk;

    function automatic int clip(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: predict from current inputs, clock, then compare
    task automatic tick(input string tag);
        int  exp_pix;
        int  need;
        int  lvl;
        int  e;
        bit  w;
        bit  was_en;
        was_en  = loop_en;
        exp_pix = clip(int'(pix_in) + m_acc, 0, 1023);
        need    = 1 << nsh;
        w       = win_sel ? win_ext : win_int;
        if (line_sync) begin
            if (loop_en && m_cnt == need) begin
                lvl   = m_sum >> nsh;
                e     = clip(int'(target) - lvl, -512, 511);
                m_acc = m_acc + ((e - m_acc) >>> nsv);
            end
            m_cnt = 0;
            m_sum = 0;
        end else if (w && m_cnt < need) begin
            m_cnt++;
            m_sum += int'(pix_in);
        end
        if (!loop_en) m_acc = 0;
        @(posedge clk);
        @(negedge clk);
        check(was_en ? "R7 pixel" : "R6 bypass pixel", int'(pix_out), exp_pix);
        check(tag, int'($signed(corr_out)), m_acc);
    endtask

    // one line: sync at cycle 0, window from ws for wl cycles on the chosen source
    task automatic run_line(input int len, input int ws, input int wl, input int lvl,
                            input string tag);
        for (int c = 0; c < len; c++) begin
            bit inwin;
            inwin     = (c >= ws) && (c < ws + wl);
            line_sync = (c == 0);
            if (win_sel) begin
                win_ext = inwin;
                win_int = 1'($urandom % 2);
            end else begin
                win_int = inwin;
                win_ext = 1'($urandom % 2);
            end
            if (inwin)
                pix_in = 10'(clip(lvl + int'($urandom % 4), 0, 1023));
            else
                pix_in = 10'($urandom % 1024);
            tick(tag);
        end
        line_sync = 1'b0;
        win_int   = 1'b0;
        win_ext   = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seed = int'($urandom(32'd2024));
        // R1: reset state with live pixels
        pix_in = 10'd500;
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1 pixel", int'(pix_out), 0);
        check("R1 corr", int'(corr_out), 0);
        rst = 1'b0;

        // R6: disabled loop passes pixels and never updates
        loop_en = 1'b0; nsv = 4'd0; nsh = 3'd2; target = 10'd300;
        run_line(30, 3, 10, 100, "R6 disabled corr");
        run_line(30, 3, 10, 100, "R6 disabled corr");

        // R4: single-line convergence
        loop_en = 1'b1;
        run_line(30, 3, 10, 60, "R4 one-line corr");
        run_line(30, 3, 10, 60, "R4 one-line corr");
        check("R4 settled", int'($signed(corr_out)), m_acc);

        // R4: error clamp both ways, with R7 saturation on the following pixels
        target = 10'd1023;
        run_line(40, 3, 8, 0, "R4 clamp high corr");
        run_line(40, 3, 8, 0, "R4 clamp high corr");
        check("R4 clamp high", int'($signed(corr_out)), 511);
        target = 10'd0;
        run_line(40, 3, 8, 1023, "R4 clamp low corr");
        run_line(40, 3, 8, 1023, "R4 clamp low corr");
        check("R4 clamp low", int'($signed(corr_out)), -512);

        // R3: short window leaves the correction unchanged
        target = 10'd200;
        run_line(30, 5, 3, 50, "R3 short window corr");
        run_line(30, 5, 3, 50, "R3 short window corr");
        check("R3 hold", int'($signed(corr_out)), -512);

        // R8: window overlapping the sync cycle
        nsh = 3'd3;
        run_line(30, 0, 8, 40, "R8 sync overlap corr");
        run_line(30, 0, 9, 40, "R8 sync overlap corr");

        // R2: external window selected, internal one toggling
        win_sel = 1'b1;
        run_line(30, 6, 12, 90, "R2 ext window corr");
        run_line(30, 6, 12, 90, "R2 ext window corr");
        win_sel = 1'b0;

        // R5: slow filter
        nsv = 4'd2; nsh = 3'd1; target = 10'd512;
        for (int i = 0; i < 6; i++) run_line(24, 2, 4, 100, "R5 slow filter corr");

        // random mix: R2 R3 R5 R6 R7 R9
        for (int i = 0; i < 300; i++) begin
            int wl;
            int ws;
            nsv     = 4'($urandom % 16);
            nsh     = 3'($urandom % 5);
            target  = 10'($urandom % 1024);
            win_sel = 1'($urandom % 2);
            loop_en = ($urandom % 8) != 0;
            wl      = (1 << nsh) + int'($urandom % 5) - 2;
            if (wl < 1) wl = 1;
            ws      = int'($urandom % 4);
            run_line(40, ws, wl, int'($urandom % 1024), "R9 random corr");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule